// File: doc/BRIEF.md
# DDR2 Autorefresh Command Scheduler

This block lives inside a DDR2 SDRAM controller and keeps the memory refreshed with no help from software. A down-counter reloaded from a programmable rate field marks each refresh interval and adds one to a small saturating backlog of owed refreshes. While refreshes are owed and the sequencer is idle, the block asks the access scheduler for the command bus. Once granted, it closes every bank with a precharge-all and waits a programmable recovery time. It then issues the autorefresh command and waits a programmable refresh cycle time before it hands the bus back.

In the precharge-all cycle the block sends a one-cycle pulse. The bank-tracking logic uses it to drop every open-row valid bit, so the first access after a refresh is always treated as a page miss. When the backlog reaches a set level, an urgent flag tells the access scheduler to yield at once. Refresh generation has no enable and cannot be stopped.

Top module: `ddr_refresh_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the pins show NOP, CKE is 1, the address is all zero, and rfsh_req, rfsh_urgent, rfsh_done and pages_inval are 0.
- R2: The interval counter starts at 0 out of reset. In every cycle where it reads 0, it loads rate_cfg and adds one owed refresh. Otherwise it counts down by one. A refresh therefore becomes owed every rate_cfg+1 cycles, and a new rate_cfg value takes effect only at the next reload. No input stops this counting.
- R3: rfsh_req is 1 exactly when at least one refresh is owed and the sequencer is idle.
- R4: A cycle with rfsh_req and rfsh_gnt both 1 starts a sequence and removes one owed refresh. The next cycle drives precharge-all: cs_n=0, ras_n=0, cas_n=1, we_n=0, with address bit 10 at 1 and all other address bits at 0.
- R5: pages_inval is 1 in the precharge-all cycle and in no other cycle.
- R6: Autorefresh (cs_n=0, ras_n=0, cas_n=0, we_n=1, address all zero) is driven max(trp_cfg,2) cycles after the precharge-all cycle.
- R7: rfsh_done pulses for one cycle max(trfc_cfg,2) cycles after the autorefresh cycle. In that same cycle the sequencer is idle again.
- R8: In every other cycle the pins show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), and CKE is always 1.
- R9: The owed-refresh count saturates at 2^PEND_W-1. If a new refresh falls due in the same cycle a sequence starts, the count is unchanged.
- R10: rfsh_urgent is 1 exactly when the owed count is at least URGENT_LVL (default 4, with PEND_W default 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_cfg | input | RATE_W | Refresh interval field, in cycles minus one |
| trp_cfg | input | TIMER_W | Precharge-to-refresh gap in cycles |
| trfc_cfg | input | TIMER_W | Refresh-to-done gap in cycles |
| rfsh_gnt | input | 1 | Command bus granted by the access scheduler |
| rfsh_req | output | 1 | Refresh wants the command bus |
| rfsh_urgent | output | 1 | Backlog high, access scheduler must yield |
| rfsh_done | output | 1 | One-cycle pulse, refresh sequence finished |
| pages_inval | output | 1 | Clear all open-row valid bits |
| cke | output | 1 | Clock enable pin |
| cs_n | output | 1 | Chip select pin |
| ras_n | output | 1 | Row strobe pin |
| cas_n | output | 1 | Column strobe pin |
| we_n | output | 1 | Write enable pin |
| addr | output | ADDR_W | Address pins |

## Verification
The interval counter can add an owed refresh in the very cycle a grant starts a sequence and removes one. The count must then stay where it was. The bench provokes this with a rate field of zero, so a refresh falls due every cycle while the grant is held, and with random grant patterns against short intervals. A behavioural model compares rfsh_req, rfsh_urgent and the pin timing on every clock, so a lost or doubled count shows up as a request or urgent flag in the wrong cycle.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_PRE,
      PH_WAIT_RP,
      PH_REF,
      PH_WAIT_RFC
   } rfsh_phase_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } ddr_cmd_t;

   localparam ddr_cmd_t CMD_NOP    = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam ddr_cmd_t CMD_PREALL = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
   localparam ddr_cmd_t CMD_AREF   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
   parameter int RATE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate_cfg,
   output logic              tick
);

   logic [RATE_W-1:0] cnt;

   assign tick = (cnt == '0);

   // R2: reload from the field at zero, count down otherwise
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= rate_cfg;
      end else begin
         cnt <= cnt - 1'b1;
      end
   end

   assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(tick)) |-> (cnt == $past(rate_cfg)));

   assert_countdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(tick)) |-> (cnt == RATE_W'($past(cnt) - 1'b1)));

endmodule

// File: rtl/rfsh_pending_ctr.sv
module rfsh_pending_ctr #(
   parameter int PEND_W     = 3,
   parameter int URGENT_LVL = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   output logic pend_nz,
   output logic urgent
);

   localparam logic [PEND_W-1:0] PEND_MAX  = {PEND_W{1'b1}};
   localparam logic [PEND_W-1:0] URG_LEVEL = PEND_W'(URGENT_LVL);

   logic [PEND_W-1:0] pend;

   // R9: saturating backlog, simultaneous inc and dec cancel
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
      end else begin
         unique case ({inc, dec})
            2'b10:   if (pend != PEND_MAX) pend <= pend + 1'b1;
            2'b01:   pend <= pend - 1'b1;
            default: pend <= pend;
         endcase
      end
   end

   assign pend_nz = (pend != '0);
   assign urgent  = (pend >= URG_LEVEL);

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == PEND_MAX && inc && !dec) |=> (pend == PEND_MAX));

   assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && dec) |=> $stable(pend));

   assert_dec_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> pend_nz);

endmodule

// File: rtl/rfsh_cmd_fsm.sv
module rfsh_cmd_fsm
   import rfsh_pkg::*;
#(
   parameter int TIMER_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pend_nz,
   input  logic               gnt,
   input  logic [TIMER_W-1:0] trp_cfg,
   input  logic [TIMER_W-1:0] trfc_cfg,
   output logic               req,
   output logic               start,
   output logic               pre_cycle,
   output logic               done,
   output ddr_cmd_t           cmd
);

   rfsh_phase_e        ph;
   logic [TIMER_W-1:0] tmr;
   logic [TIMER_W:0]   tmr_nxt;

   assign req     = (ph == PH_IDLE) && pend_nz;
   assign start   = req && gnt;
   assign tmr_nxt = {1'b0, tmr} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph   <= PH_IDLE;
         tmr  <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (ph)
            PH_IDLE: if (start) ph <= PH_PRE;
            PH_PRE: begin
               ph  <= PH_WAIT_RP;
               tmr <= TIMER_W'(1);
            end
            PH_WAIT_RP: begin
               if (tmr_nxt >= {1'b0, trp_cfg}) ph <= PH_REF;
               else tmr <= tmr + 1'b1;
            end
            PH_REF: begin
               ph  <= PH_WAIT_RFC;
               tmr <= TIMER_W'(1);
            end
            PH_WAIT_RFC: begin
               if (tmr_nxt >= {1'b0, trfc_cfg}) begin
                  ph   <= PH_IDLE;
                  done <= 1'b1;
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (ph)
         PH_PRE:  cmd = CMD_PREALL;
         PH_REF:  cmd = CMD_AREF;
         default: cmd = CMD_NOP;
      endcase
   end

   assign pre_cycle = (ph == PH_PRE);

   assert_req_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ph != PH_IDLE) |-> !req);

   assert_ref_after_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_REF) |-> ($past(ph) == PH_WAIT_RP));

   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ph == PH_IDLE && $past(ph) == PH_WAIT_RFC));

endmodule

// File: rtl/ddr_refresh_sched.sv
module ddr_refresh_sched
   import rfsh_pkg::*;
#(
   parameter int RATE_W     = 16,
   parameter int TIMER_W    = 8,
   parameter int PEND_W     = 3,
   parameter int URGENT_LVL = 4,
   parameter int ADDR_W     = 14,
   parameter int AP_BIT     = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [RATE_W-1:0]  rate_cfg,
   input  logic [TIMER_W-1:0] trp_cfg,
   input  logic [TIMER_W-1:0] trfc_cfg,
   input  logic               rfsh_gnt,
   output logic               rfsh_req,
   output logic               rfsh_urgent,
   output logic               rfsh_done,
   output logic               pages_inval,
   output logic               cke,
   output logic               cs_n,
   output logic               ras_n,
   output logic               cas_n,
   output logic               we_n,
   output logic [ADDR_W-1:0]  addr
);

   localparam int PEND_MAX = (1 << PEND_W) - 1;

   if (PEND_W < 2) begin : g_chk_pend
      $error("PEND_W must be at least 2");
   end
   if (URGENT_LVL < 1 || URGENT_LVL > PEND_MAX) begin : g_chk_urg
      $error("URGENT_LVL must lie in 1 .. 2**PEND_W-1");
   end
   if (AP_BIT >= ADDR_W) begin : g_chk_ap
      $error("AP_BIT must be below ADDR_W");
   end
   if (RATE_W < 1 || TIMER_W < 2) begin : g_chk_w
      $error("RATE_W must be >= 1 and TIMER_W >= 2");
   end

   logic     tick;
   logic     pend_nz;
   logic     start;
   logic     pre_cycle;
   ddr_cmd_t cmd;

   rfsh_interval_timer #(.RATE_W(RATE_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_cfg (rate_cfg),
      .tick     (tick)
   );

   rfsh_pending_ctr #(.PEND_W(PEND_W), .URGENT_LVL(URGENT_LVL)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (tick),
      .dec     (start),
      .pend_nz (pend_nz),
      .urgent  (rfsh_urgent)
   );

   rfsh_cmd_fsm #(.TIMER_W(TIMER_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend_nz   (pend_nz),
      .gnt       (rfsh_gnt),
      .trp_cfg   (trp_cfg),
      .trfc_cfg  (trfc_cfg),
      .req       (rfsh_req),
      .start     (start),
      .pre_cycle (pre_cycle),
      .done      (rfsh_done),
      .cmd       (cmd)
   );

   assign cke         = 1'b1;
   assign cs_n        = cmd.cs_n;
   assign ras_n       = cmd.ras_n;
   assign cas_n       = cmd.cas_n;
   assign we_n        = cmd.we_n;
   assign pages_inval = pre_cycle;

   // R4: only the auto-precharge bit is ever driven high
   for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_addr
      if (gi == AP_BIT) begin : g_ap
         assign addr[gi] = pre_cycle;
      end else begin : g_zero
         assign addr[gi] = 1'b0;
      end
   end

   assert_inval_is_preall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pages_inval |-> (!cs_n && !ras_n && cas_n && !we_n && addr[AP_BIT]));

   assert_inval_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pages_inval |=> !pages_inval);

   assert_grant_to_pre_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rfsh_req && rfsh_gnt) |=> pages_inval);

   assert_done_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_done |-> (!cs_n && ras_n && cas_n && we_n));

endmodule

// File: tb/ddr_refresh_sched_tb_top.sv
module ddr_refresh_sched_tb_top;

   localparam int RATE_W = 16, TIMER_W = 8, PEND_W = 3, URGENT_LVL = 4;
   localparam int ADDR_W = 14, AP_BIT = 10;
   localparam int PMAX = (1 << PEND_W) - 1;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic               rst_n;
   logic [RATE_W-1:0]  rate_cfg;
   logic [TIMER_W-1:0] trp_cfg, trfc_cfg;
   logic               rfsh_gnt;
   logic rfsh_req, rfsh_urgent, rfsh_done, pages_inval, cke, cs_n, ras_n, cas_n, we_n;
   logic [ADDR_W-1:0]  addr;

   ddr_refresh_sched #(
      .RATE_W(RATE_W), .TIMER_W(TIMER_W), .PEND_W(PEND_W),
      .URGENT_LVL(URGENT_LVL), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .rate_cfg(rate_cfg), .trp_cfg(trp_cfg),
      .trfc_cfg(trfc_cfg), .rfsh_gnt(rfsh_gnt), .rfsh_req(rfsh_req),
      .rfsh_urgent(rfsh_urgent), .rfsh_done(rfsh_done), .pages_inval(pages_inval),
      .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   // behavioural model: interval countdown, owed count, step in sequence, age
   int m_cnt, m_owed, m_step, m_age;
   bit m_done;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_owed = 0; m_step = 0; m_age = 0; m_done = 0;
      end else begin
         bit due, go;
         due = (m_cnt == 0);
         go  = (m_step == 0) && (m_owed > 0) && rfsh_gnt;
         m_cnt = due ? int'(rate_cfg) : m_cnt - 1;
         if (due && !go && m_owed < PMAX) m_owed++;
         else if (go && !due) m_owed--;
         m_done = 0;
         case (m_step)
            0: if (go) m_step = 1;
            1: begin m_step = 2; m_age = 1; end
            2: if (m_age + 1 >= int'(trp_cfg)) m_step = 3; else m_age++;
            3: begin m_step = 4; m_age = 1; end
            default: if (m_age + 1 >= int'(trfc_cfg)) begin m_step = 0; m_done = 1; end
                     else m_age++;
         endcase
      end
   end

   // compare every cycle away from the active edge
   always @(negedge clk) begin
      if (!finished) begin
         int pins;
         pins = {cs_n, ras_n, cas_n, we_n};
         if (m_step == 1) begin
            chk("R4 precharge-all pins", pins, 4'b0010);
            chk("R4 address bit 10 only", int'(addr), 1 << AP_BIT);
         end else if (m_step == 3) begin
            chk("R6 autorefresh pins", pins, 4'b0001);
            chk("R6 address zero", int'(addr), 0);
         end else begin
            chk("R8 NOP pins", pins, 4'b0111);
            chk("R8 address zero", int'(addr), 0);
         end
         chk("R8 cke high", int'(cke), 1);
         chk("R5 pages_inval", int'(pages_inval), int'(m_step == 1));
         chk("R3 R2 rfsh_req", int'(rfsh_req), int'(m_step == 0 && m_owed > 0));
         chk("R10 R9 rfsh_urgent", int'(rfsh_urgent), int'(m_owed >= URGENT_LVL));
         chk("R7 rfsh_done", int'(rfsh_done), int'(m_done));
      end
   end

   task automatic run(input int n);
      repeat (n) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic summary();
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      rst_n = 1'b0; rate_cfg = 16'd20; trp_cfg = 8'd3; trfc_cfg = 8'd5; rfsh_gnt = 1'b0;
      run(3);
      // R1: reset state
      chk("R1 reset req", int'(rfsh_req), 0);
      chk("R1 reset urgent", int'(rfsh_urgent), 0);
      chk("R1 reset done", int'(rfsh_done), 0);
      chk("R1 reset inval", int'(pages_inval), 0);
      chk("R1 reset pins", int'({cke, cs_n, ras_n, cas_n, we_n}), 5'b10111);
      chk("R1 reset addr", int'(addr), 0);
      rst_n = 1'b1;
      // R2 R4 R6 R7: steady granting
      rfsh_gnt = 1'b1;
      run(120);
      // R9 R10: backlog builds and saturates without grant
      rfsh_gnt = 1'b0; rate_cfg = 16'd3;
      run(60);
      rate_cfg = 16'd40; rfsh_gnt = 1'b1;
      run(120);
      // R9: refresh due every cycle, coincides with each start; R6 R7 minimum gaps
      trp_cfg = 8'd0; trfc_cfg = 8'd1; rate_cfg = 16'd0;
      run(60);
      // R2: rate change mid-count takes effect at next reload
      rate_cfg = 16'd30; trp_cfg = 8'd4; trfc_cfg = 8'd2;
      run(10);
      rate_cfg = 16'd2;
      run(50);
      // mixed grant pattern against short intervals
      rate_cfg = 16'd5;
      for (int i = 0; i < 300; i++) begin
         rfsh_gnt = 1'($urandom % 2);
         run(1);
      end
      rfsh_gnt = 1'b1;
      run(80);
      summary();
   end

   initial begin
      repeat (5000) @(posedge clk);
      fails++;
      $display("FAIL R7 watchdog act=running exp=finished");
      summary();
   end

endmodule